// File: doc/BRIEF.md
# E1 Receive Frame-Sync Pulse Generator

This block drives the frame-sync pin that goes with received E1 data on a backplane. It runs on the bit clock and keeps three position counters: the bit within the basic frame, the frame within the CRC multiframe, and the frame within the signaling multiframe. An upstream framer supplies alignment references that snap each counter back to zero. A three-bit mode field chooses what the pin marks: every basic frame, each CRC multiframe, each signaling multiframe, a level that spans both multiframes, or the two overhead timeslots of each frame. A polarity bit sets the active level.

The pin can be moved ahead of the data by a whole number of timeslots, so that a downstream device sees the sync pulse before the frame it belongs to. Only the overhead-timeslot mode ignores this offset. The interface works in two ways. A plain link carries 32 timeslots per frame. The multiplexed form carries 128 byte-interleaved timeslots per frame, four links deep, and allows a wider offset. Configuration is taken in only at a frame boundary, so reprogramming never cuts a pulse short and never adds a stray one.

Top module: `e1_rx_fsync_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `fsyncOut` is 0. The bit position starts at 0, both multiframe frame indices start at 0, and the latched configuration starts as mode 000, polarity 0, offset 0, non-multiplexed.
- R2: With mode 000 the pin is active for one bit, the first bit of every basic frame. The output is registered, so the level that marks a bit appears on the clock edge that ends that bit.
- R3: With mode 001 the pin is active for one bit at the first bit of frame 0 of each CRC multiframe.
- R4: With mode 010 the pin is active for one bit at the first bit of frame 0 of each signaling multiframe.
- R5: With mode 011 the pin goes active at the first bit of each signaling multiframe and goes inactive at the second bit of each CRC multiframe. Between those two events it keeps its level. The level is tracked in every mode and starts inactive after reset.
- R6: With mode 100 the pin is active for every bit of the overhead timeslots, and the offset has no effect. On a plain link these are timeslot indices 0 and 16 (index = bit position / 8). In multiplexed mode they are the timeslots whose index / 4 is 0 or 16.
- R7: Mode codes 101, 110 and 111 hold the pin at its inactive level.
- R8: Polarity 0 makes the active level 1. Polarity 1 makes the active level 0.
- R9: A nonzero offset of N timeslots moves every mode-000 to mode-011 event 8*N bit clocks earlier. An event moved before bit 0 moves into the previous frame, and into the previous multiframe where that applies.
- R10: On a plain link only offset bits 4:0 are used (range 0 to 31), so bits 6:5 have no effect. In multiplexed mode all seven bits are used (range 0 to 127).
- R11: A frame is 256 bit clocks on a plain link and 1024 in multiplexed mode, and each multiframe is 16 frames. `frameStart` forces the current bit to position 0. `crcMfStart` and `sigMfStart` force the current frame index of their multiframe to 0.
- R12: Mode, polarity, offset and the multiplexed flag are sampled only during the last bit of a frame, and they govern the pin from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Marks bit 0 of a basic frame |
| crcMfStart | input | 1 | Marks frame 0 of a CRC multiframe (with frameStart) |
| sigMfStart | input | 1 | Marks frame 0 of a signaling multiframe (with frameStart) |
| muxMode | input | 1 | 1 selects the four-link multiplexed format |
| fsMode | input | 3 | Pin meaning selector |
| fsInvert | input | 1 | 1 makes the pin active low |
| tsOffset | input | 7 | Lead of the pin over the data, in timeslots |
| fsyncOut | output | 1 | Frame-sync pin |

## Verification
The references come from a bench framer that places the signaling multiframe five frames after the CRC multiframe. Because of that gap, a pin that confuses the two multiframes lands in the wrong frame, and the combined level lasts the wrong length. Each mode is run with offset 0, with offsets that push events into the previous frame and multiframe, and with offsets whose upper bits must be dropped on a plain link. Mode, offset, polarity and format are changed part-way through frames, which shows whether a new setting waits for the boundary. Fixed-seed random configurations, including the multiplexed format, fill in the combinations between these points.

// File: rtl/e1fp_pkg.sv
package e1fp_pkg;

  localparam int TS_BITS       = 8;   // bits per timeslot
  localparam int TS_PER_FRAME  = 32;  // timeslots on a plain link
  localparam int MUX_LINKS     = 4;   // links interleaved in multiplexed form
  localparam int FRAMES_PER_MF = 16;  // frames per CRC or signaling multiframe
  localparam int OFF_W         = 7;
  localparam int MODE_W        = 3;

  localparam int FRAME_BITS     = TS_BITS * TS_PER_FRAME;
  localparam int MUX_FRAME_BITS = FRAME_BITS * MUX_LINKS;
  localparam int POS_W          = $clog2(MUX_FRAME_BITS);
  localparam int FRM_W          = $clog2(FRAMES_PER_MF);
  localparam int TS_SHIFT       = $clog2(TS_BITS);
  localparam int LINK_SHIFT     = $clog2(MUX_LINKS);
  localparam int STD_OFF_W      = $clog2(TS_PER_FRAME);

  localparam logic [MODE_W-1:0] MODE_BASIC    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_CRCMF    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_SIGMF    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_COMBO    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_OVERHEAD = 3'd4;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              inv;
    logic [OFF_W-1:0]  off;
    logic              mux;
  } fpCfg_t;

  // Strobes and position from control to datapath
  typedef struct packed {
    logic [POS_W-1:0] bitPos;
    logic [FRM_W-1:0] crcFrm;
    logic [FRM_W-1:0] sigFrm;
    logic             lastBit;
    fpCfg_t           cfg;
  } fpStrobe_t;

endpackage

// File: rtl/e1fp_ctrl.sv
module e1fp_ctrl
  import e1fp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      crcMfStart,
  input  logic      sigMfStart,
  input  fpCfg_t    cfgIn,
  output fpStrobe_t strb
);

  localparam logic [POS_W-1:0] LAST_STD = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] LAST_MUX = POS_W'(MUX_FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(FRAMES_PER_MF - 1);

  logic [POS_W-1:0] bitCnt;
  logic [FRM_W-1:0] crcCnt;
  logic [FRM_W-1:0] sigCnt;
  fpCfg_t           cfgQ;

  logic [POS_W-1:0] curBit;
  logic [FRM_W-1:0] curCrc;
  logic [FRM_W-1:0] curSig;
  logic             atLast;

  function automatic logic [FRM_W-1:0] frmInc(input logic [FRM_W-1:0] f);
    return (f == LAST_FRM) ? '0 : f + 1'b1;
  endfunction

  // R11: references realign the counters in the bit they mark
  always_comb begin
    curBit = frameStart ? '0 : bitCnt;
    curCrc = crcMfStart ? '0 : crcCnt;
    curSig = sigMfStart ? '0 : sigCnt;
    atLast = (curBit == (cfgQ.mux ? LAST_MUX : LAST_STD));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      crcCnt <= '0;
      sigCnt <= '0;
      cfgQ   <= '0;   // R1
    end else begin
      bitCnt <= atLast ? '0 : curBit + 1'b1;
      crcCnt <= atLast ? frmInc(curCrc) : curCrc;
      sigCnt <= atLast ? frmInc(curSig) : curSig;
      if (atLast) cfgQ <= cfgIn;   // R12: boundary-only update
    end
  end

  always_comb begin
    strb.bitPos  = curBit;
    strb.crcFrm  = curCrc;
    strb.sigFrm  = curSig;
    strb.lastBit = atLast;
    strb.cfg     = cfgQ;
  end

endmodule

// File: rtl/e1fp_dpath.sv
module e1fp_dpath
  import e1fp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  fpStrobe_t strb,
  output logic      fsyncOut
);

  localparam logic [POS_W:0]     LEN_STD  = (POS_W+1)'(FRAME_BITS);
  localparam logic [POS_W:0]     LEN_MUX  = (POS_W+1)'(MUX_FRAME_BITS);
  localparam logic [OFF_W-1:0]   STD_MASK = OFF_W'((1 << STD_OFF_W) - 1);
  localparam logic [FRM_W-1:0]   LAST_FRM = FRM_W'(FRAMES_PER_MF - 1);
  localparam logic [POS_W-1:0]   OH_MID   = POS_W'(TS_PER_FRAME / 2);

  logic [POS_W:0]   frameLen;
  logic [OFF_W-1:0] offEff;
  logic [POS_W:0]   offBits;
  logic [POS_W:0]   sum;
  logic             wrapV;
  logic [POS_W:0]   vFull;
  logic [POS_W-1:0] vBit;
  logic             frameHit;
  logic             secondBit;

  logic [1:0][FRM_W-1:0] mfNow;
  logic [1:0][FRM_W-1:0] mfAhead;
  logic [1:0]            mfHead;

  logic [POS_W-1:0] tsIdx;
  logic [POS_W-1:0] linkTs;
  logic             ohHit;

  logic comboQ;
  logic comboNext;
  logic active;

  // R10: plain link keeps only the low offset bits
  // R9: look ahead by the offset, carrying into the next frame
  always_comb begin
    frameLen  = strb.cfg.mux ? LEN_MUX : LEN_STD;
    offEff    = strb.cfg.mux ? strb.cfg.off : (strb.cfg.off & STD_MASK);
    offBits   = (POS_W+1)'(offEff) << TS_SHIFT;
    sum       = {1'b0, strb.bitPos} + offBits;
    wrapV     = (sum >= frameLen);
    vFull     = wrapV ? (sum - frameLen) : sum;
    vBit      = vFull[POS_W-1:0];
    frameHit  = (vBit == '0);
    secondBit = (vBit == POS_W'(1));
  end

  assign mfNow[0] = strb.crcFrm;
  assign mfNow[1] = strb.sigFrm;

  // One lookahead path per multiframe kind (0 = CRC, 1 = signaling)
  for (genvar g = 0; g < 2; g++) begin : gMfLook
    assign mfAhead[g] = !wrapV ? mfNow[g]
                      : ((mfNow[g] == LAST_FRM) ? '0 : mfNow[g] + 1'b1);
    assign mfHead[g]  = frameHit && (mfAhead[g] == '0);
  end

  // R6: overhead timeslots from the unshifted position
  always_comb begin
    tsIdx  = strb.bitPos >> TS_SHIFT;
    linkTs = strb.cfg.mux ? (tsIdx >> LINK_SHIFT) : tsIdx;
    ohHit  = (linkTs == '0) || (linkTs == OH_MID);
  end

  // R5: set on signaling head, clear on second bit of CRC multiframe
  always_comb begin
    comboNext = comboQ;
    if (mfHead[1])
      comboNext = 1'b1;
    else if (secondBit && (mfAhead[0] == '0))
      comboNext = 1'b0;
  end

  always_comb begin
    case (strb.cfg.mode)
      MODE_BASIC:    active = frameHit;   // R2
      MODE_CRCMF:    active = mfHead[0];  // R3
      MODE_SIGMF:    active = mfHead[1];  // R4
      MODE_COMBO:    active = comboNext;  // R5
      MODE_OVERHEAD: active = ohHit;      // R6
      default:       active = 1'b0;       // R7
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comboQ   <= 1'b0;
      fsyncOut <= 1'b0;
    end else begin
      comboQ   <= comboNext;
      fsyncOut <= active ^ strb.cfg.inv;   // R8
    end
  end

endmodule

// File: rtl/e1_rx_fsync_gen.sv
module e1_rx_fsync_gen
  import e1fp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              crcMfStart,
  input  logic              sigMfStart,
  input  logic              muxMode,
  input  logic [MODE_W-1:0] fsMode,
  input  logic              fsInvert,
  input  logic [OFF_W-1:0]  tsOffset,
  output logic              fsyncOut
);

  fpCfg_t    cfgIn;
  fpStrobe_t strb;

  always_comb begin
    cfgIn.mode = fsMode;
    cfgIn.inv  = fsInvert;
    cfgIn.off  = tsOffset;
    cfgIn.mux  = muxMode;
  end

  e1fp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .crcMfStart (crcMfStart),
    .sigMfStart (sigMfStart),
    .cfgIn      (cfgIn),
    .strb       (strb)
  );

  e1fp_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .fsyncOut (fsyncOut)
  );

endmodule

// File: rtl/e1fp_chk.sv
module e1fp_chk
  import e1fp_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      frameStart,
  input logic      fsyncOut,
  input fpStrobe_t strb
);

  always @(posedge clk) begin
    if (!rstN) AST_RESET_IDLE: assert (fsyncOut == 1'b0); // R1
  end

  AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lastBit |=> (frameStart || (strb.bitPos == $past(strb.bitPos) + 1'b1))); // R11

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lastBit |=> $stable(strb.cfg)); // R12

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cfg.mode > MODE_OVERHEAD) |=> (fsyncOut == $past(strb.cfg.inv))); // R7

  AST_OVERHEAD_ON: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cfg.mode == MODE_OVERHEAD && strb.bitPos == '0)
      |=> (fsyncOut != $past(strb.cfg.inv))); // R6

  AST_OVERHEAD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cfg.mode == MODE_OVERHEAD && !strb.cfg.mux && strb.bitPos == POS_W'(TS_BITS))
      |=> (fsyncOut == $past(strb.cfg.inv))); // R6

endmodule

bind e1_rx_fsync_gen e1fp_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .fsyncOut   (fsyncOut),
  .strb       (strb)
);

// File: tb/e1_rx_fsync_gen_tb.sv
`timescale 1ns/1ps
module e1_rx_fsync_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0;
  logic       crcMfStart = 1'b0;
  logic       sigMfStart = 1'b0;
  logic       muxMode = 1'b0;
  logic [2:0] fsMode = 3'd0;
  logic       fsInvert = 1'b0;
  logic [6:0] tsOffset = 7'd0;
  logic       fsyncOut;

  int checks = 0;
  int errors = 0;

  // pending configuration driven each bit
  int pMode = 0, pInv = 0, pOff = 0, pMux = 0;
  // model state
  int mBit = 0, mCrc = 0, mSig = 0;
  int sMode = 0, sInv = 0, sOff = 0, sMux = 0;
  int mCombo = 0;
  int expOut = 0;
  bit havePrev = 0;
  string expTag = "";
  string phaseTag = "";
  int cyc = 0;

  localparam int SIG_GAP = 5;  // signaling multiframe starts at CRC frame 5

  always #2 clk = ~clk;

  e1_rx_fsync_gen u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .crcMfStart(crcMfStart),
    .sigMfStart(sigMfStart), .muxMode(muxMode), .fsMode(fsMode),
    .fsInvert(fsInvert), .tsOffset(tsOffset), .fsyncOut(fsyncOut)
  );

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: fsyncOut got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  function automatic string modeTag(input int md);
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // One bit clock: check previous bit's result, drive this bit, predict.
  task automatic step();
    int len, offE, lead, mfLen, vc, vs;
    bit frmHit, crcHit, sigHit, crc2, oh, act;
    int ts, lt;
    @(negedge clk);
    cyc++;
    if (havePrev) check(int'(fsyncOut), expOut, expTag);

    len = sMux ? 1024 : 256;
    frameStart = (mBit == 0);
    crcMfStart = (mBit == 0) && (mCrc == 0);
    sigMfStart = (mBit == 0) && (mCrc == SIG_GAP);
    if (sigMfStart) mSig = 0;
    fsMode   = 3'(pMode);
    fsInvert = pInv[0];
    tsOffset = 7'(pOff);
    muxMode  = pMux[0];

    offE  = sMux ? sOff : (sOff % 32);
    lead  = offE * 8;
    mfLen = 16 * len;
    vc = (mCrc * len + mBit + lead) % mfLen;
    vs = (mSig * len + mBit + lead) % mfLen;
    frmHit = ((mBit + lead) % len) == 0;
    crcHit = (vc == 0);
    sigHit = (vs == 0);
    crc2   = (vc == 1);
    ts = mBit / 8;
    lt = sMux ? ts / 4 : ts;
    oh = (lt == 0) || (lt == 16);
    if (sigHit) mCombo = 1;
    else if (crc2) mCombo = 0;
    case (sMode)
      0: act = frmHit;
      1: act = crcHit;
      2: act = sigHit;
      3: act = mCombo[0];
      4: act = oh;
      default: act = 1'b0;
    endcase
    expOut = int'(act) ^ sInv;
    expTag = $sformatf("%s/%s", modeTag(sMode), phaseTag);
    havePrev = 1;

    if (mBit == len - 1) begin
      mBit = 0;
      mCrc = (mCrc + 1) % 16;
      mSig = (mSig + 1) % 16;
      sMode = pMode; sInv = pInv; sOff = pOff; sMux = pMux;   // R12
    end else begin
      mBit++;
    end
  endtask

  task automatic runPhase(input int md, input int inv, input int off, input int mux,
                          input int frames, input string tag);
    int n;
    pMode = md; pInv = inv; pOff = off; pMux = mux;
    phaseTag = tag;
    n = frames * (mux ? 1024 : 256) + 77;  // end mid-frame to exercise R12
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0E1F);
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(int'(fsyncOut), 0, "R1 reset");
    end
    rstN = 1'b1;

    runPhase(0, 0, 0, 0, 3, "R2");
    runPhase(1, 0, 0, 0, 17, "R3");
    runPhase(2, 0, 3, 0, 17, "R4/R9");
    runPhase(3, 0, 0, 0, 17, "R5");
    runPhase(3, 0, 31, 0, 17, "R5/R9");
    runPhase(1, 0, 2, 0, 17, "R9");
    runPhase(4, 0, 20, 0, 3, "R6");
    runPhase(5, 0, 9, 0, 2, "R7");
    runPhase(6, 1, 9, 0, 2, "R7/R8");
    runPhase(7, 0, 0, 0, 2, "R7");
    runPhase(1, 1, 0, 0, 17, "R8");
    runPhase(1, 0, 100, 0, 17, "R10");      // only low 5 bits used: 4
    runPhase(0, 0, 0, 1, 2, "R11");
    runPhase(4, 1, 50, 1, 2, "R6/R11");
    runPhase(1, 0, 100, 1, 17, "R10");
    runPhase(0, 0, 0, 0, 0, "R12");         // short stretches, mid-frame changes
    runPhase(2, 1, 5, 0, 1, "R12");
    runPhase(0, 0, 7, 0, 0, "R12");

    for (int k = 0; k < 6; k++) begin
      int md, inv, off, mux, fr;
      md  = $urandom % 8;
      inv = $urandom % 2;
      off = $urandom % 128;
      mux = (($urandom % 4) == 0) ? 1 : 0;
      fr  = mux ? 17 : 18;
      runPhase(md, inv, off, mux, fr, "random");
    end
    @(negedge clk);
    check(int'(fsyncOut), expOut, expTag);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule